// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers eight active-low external interrupt pins and 43 internal peripheral request lines into 51 interrupt sources. Each source has its own pending flag. Each external pin can be set to sense a falling edge or a low level. The pins pass through a two-flop synchronizer before detection, and detection does not depend on how the pin is otherwise configured. A source competes for service only while its pending flag and its enable bit are both 1.

Sources are grouped in fours, and each group has a 3-bit programmable priority level. The block picks the pending source with the highest level. When levels are equal, the lower vector number wins. The winner goes to the CPU with a request strobe, its vector number and its level, but only if its level beats the CPU's current mask level. Any source can instead be routed to a transfer controller. Routed sources are arbitrated on a separate output, ignore the CPU mask and never reach the CPU port.

Software clears a pending flag in two steps: it reads the flag as 1, then writes 0 to it.

Top module: `irq_vec_ctrl`

## Requirements
- R1: Source index i carries vector number 16+i. External pin IRQn is index n (vectors 16 to 23), and internal line k is index 8+k (vectors 24 to 66). The flag read and write ports address sources by this index.
- R2: A source takes part in arbitration only when its pending flag is 1 and its src_en bit is 1. A flag that is set while the source is disabled stays latched and is served once the source is enabled.
- R3: Source i belongs to group i/4, whose level is grp_lvl[3g+2:3g]. The highest level wins. Among equal levels, whether in different groups or the same group, the lowest vector number wins.
- R4: The CPU winner is presented only if its level is strictly greater than cpu_mask, or if its level is 7.
- R5: A source whose src_to_xfer bit is 1 is arbitrated onto the xfer_* outputs regardless of cpu_mask, and never appears on the cpu_* outputs.
- R6: With irq_edge[n]=1, a falling edge on irq_n[n] sets flag n once. The request appears on the outputs at the 4th rising clock edge after the pin change. Holding the pin low does not set the flag again after it is cleared.
- R7: With irq_edge[n]=0, the flag sets while irq_n[n] is low and sets again after a clear for as long as the pin stays low.
- R8: A flag is cleared only by a write with wr_data=0 to its index after a read (rd_en) that returned 1 for that index. A write of 0 without that read, or a write of 1, leaves the flag set.
- R9: If a set event and a valid clear hit the same flag in the same cycle, the flag stays set.
- R10: The outputs are registered. An internal request pulse sets its flag at one edge and appears on the outputs at the next edge. cpu_req and xfer_req drop one edge after no qualifying request remains.
- R11: After reset all flags are 0, and cpu_req, xfer_req and rd_flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n | input | 8 | External interrupt pins, active low |
| irq_edge | input | 8 | Per pin: 1 = falling-edge sense, 0 = low-level sense |
| int_req | input | 43 | Internal peripheral request lines, each sets its flag while 1 |
| src_en | input | 51 | Per-source enable |
| src_to_xfer | input | 51 | Per-source route to the transfer controller |
| grp_lvl | input | 39 | 3-bit priority level per group of four sources |
| cpu_mask | input | 3 | CPU current mask level |
| rd_en | input | 1 | Flag read strobe |
| rd_idx | input | 6 | Source index to read |
| wr_en | input | 1 | Flag write strobe |
| wr_idx | input | 6 | Source index to write |
| wr_data | input | 1 | Written value; 0 clears an armed flag |
| rd_flag | output | 1 | Flag value read, one cycle after rd_en |
| cpu_req | output | 1 | CPU interrupt request |
| cpu_vec | output | 8 | Vector number of the CPU winner |
| cpu_lvl | output | 3 | Level of the CPU winner |
| xfer_req | output | 1 | Transfer controller request |
| xfer_vec | output | 8 | Vector number of the transfer winner |
| xfer_lvl | output | 3 | Level of the transfer winner |

## Verification
An internal pulse driven before a rising edge sets its flag at that edge, and the outputs follow at the next edge. An external pin change appears at the fourth edge: two synchronizer flops, the flag, then the output register. A change to enable, level, mask or route shows at the next edge, as does a clear, one edge after its write. The bench drives every input at the falling edge and samples at the falling edge after the counted number of rising edges. For external pins it also samples one edge early to confirm the request has not yet appeared.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
    localparam int LVL_W    = 3;
    localparam int VEC_W    = 8;
    localparam int VEC_BASE = 16;

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [VEC_W-1:0] vec_t;

    typedef struct packed {
        logic valid;
        vec_t vec;
        lvl_t lvl;
    } arb_out_t;
endpackage

// File: rtl/irq_pin_sense.sv
module irq_pin_sense #(
    parameter int NUM_PIN = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_PIN-1:0] pin_n,
    input  logic [NUM_PIN-1:0] edge_mode,
    output logic [NUM_PIN-1:0] set_ev
);
    typedef struct packed {
        logic [NUM_PIN-1:0] s1;
        logic [NUM_PIN-1:0] s2;
        logic [NUM_PIN-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = pin_n;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{s1: '1, s2: '1, prev: '1};
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
        assign set_ev[p] = edge_mode[p] ? (st_q.prev[p] & ~st_q.s2[p]) : ~st_q.s2[p];
    end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int N     = 51,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     set_ev,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_data,
    output logic [N-1:0]     flags,
    output logic             rd_flag
);
    typedef struct packed {
        logic [N-1:0] flag;
        logic [N-1:0] armed;
        logic         rd_flag;
    } bank_t;

    bank_t bk_d, bk_q;
    logic [N-1:0] clr;

    always_comb begin
        bk_d = bk_q;
        clr  = '0;
        if (wr_en && !wr_data && (int'(wr_idx) < N)) begin
            if (bk_q.armed[wr_idx]) begin
                clr[wr_idx] = 1'b1;
            end
        end
        // a set event in the same cycle overrides the clear
        bk_d.flag  = set_ev | (bk_q.flag & ~clr);
        bk_d.armed = bk_q.armed & ~clr;
        if (rd_en && (int'(rd_idx) < N)) begin
            bk_d.rd_flag = bk_q.flag[rd_idx];
            if (bk_q.flag[rd_idx]) begin
                bk_d.armed[rd_idx] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bk_q <= '0;
        end else begin
            bk_q <= bk_d;
        end
    end

    assign flags   = bk_q.flag;
    assign rd_flag = bk_q.rd_flag;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_vec_pkg::*;
#(
    parameter int N          = 51,
    parameter bit APPLY_MASK = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N-1:0]       cand,
    input  logic [N*LVL_W-1:0] src_lvl,
    input  lvl_t               mask,
    output arb_out_t           result
);
    arb_out_t res_d, res_q;
    logic     found;
    lvl_t     best_lvl;
    vec_t     best_vec;
    logic     pass;

    always_comb begin
        found    = 1'b0;
        best_lvl = '0;
        best_vec = '0;
        // ascending scan with strict compare keeps the lowest vector on ties
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (!found || (src_lvl[i*LVL_W +: LVL_W] > best_lvl))) begin
                found    = 1'b1;
                best_lvl = src_lvl[i*LVL_W +: LVL_W];
                best_vec = vec_t'(VEC_BASE + i);
            end
        end
        pass      = found && (!APPLY_MASK || (best_lvl > mask) || (best_lvl == '1));
        res_d     = res_q;
        res_d.valid = pass;
        res_d.vec   = pass ? best_vec : '0;
        res_d.lvl   = pass ? best_lvl : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign result = res_q;
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
    import irq_vec_pkg::*;
#(
    parameter int NUM_EXT  = 8,
    parameter int NUM_INT  = 43,
    parameter int GRP_SIZE = 4,
    localparam int NUM_SRC = NUM_EXT + NUM_INT,
    localparam int IDX_W   = $clog2(NUM_SRC),
    localparam int NUM_GRP = (NUM_SRC + GRP_SIZE - 1) / GRP_SIZE
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_EXT-1:0]       irq_n,
    input  logic [NUM_EXT-1:0]       irq_edge,
    input  logic [NUM_INT-1:0]       int_req,
    input  logic [NUM_SRC-1:0]       src_en,
    input  logic [NUM_SRC-1:0]       src_to_xfer,
    input  logic [NUM_GRP*LVL_W-1:0] grp_lvl,
    input  logic [LVL_W-1:0]         cpu_mask,
    input  logic                     rd_en,
    input  logic [IDX_W-1:0]         rd_idx,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic                     wr_data,
    output logic                     rd_flag,
    output logic                     cpu_req,
    output logic [VEC_W-1:0]         cpu_vec,
    output logic [LVL_W-1:0]         cpu_lvl,
    output logic                     xfer_req,
    output logic [VEC_W-1:0]         xfer_vec,
    output logic [LVL_W-1:0]         xfer_lvl
);
    logic [NUM_EXT-1:0]       ext_ev;
    logic [NUM_SRC-1:0]       set_ev;
    logic [NUM_SRC-1:0]       flag_vec;
    logic [NUM_SRC-1:0]       pend;
    logic [NUM_SRC*LVL_W-1:0] src_lvl;
    arb_out_t                 cpu_res, xfer_res;

    irq_pin_sense #(.NUM_PIN(NUM_EXT)) u_sense (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_n     (irq_n),
        .edge_mode (irq_edge),
        .set_ev    (ext_ev)
    );

    assign set_ev = {int_req, ext_ev};

    irq_flag_bank #(.N(NUM_SRC), .IDX_W(IDX_W)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_ev  (set_ev),
        .rd_en   (rd_en),
        .rd_idx  (rd_idx),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .flags   (flag_vec),
        .rd_flag (rd_flag)
    );

    assign pend = flag_vec & src_en;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_lvl
        assign src_lvl[i*LVL_W +: LVL_W] = grp_lvl[(i / GRP_SIZE)*LVL_W +: LVL_W];
    end

    irq_arbiter #(.N(NUM_SRC), .APPLY_MASK(1'b1)) u_cpu_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .cand    (pend & ~src_to_xfer),
        .src_lvl (src_lvl),
        .mask    (cpu_mask),
        .result  (cpu_res)
    );

    irq_arbiter #(.N(NUM_SRC), .APPLY_MASK(1'b0)) u_xfer_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .cand    (pend & src_to_xfer),
        .src_lvl (src_lvl),
        .mask    (cpu_mask),
        .result  (xfer_res)
    );

    assign cpu_req  = cpu_res.valid;
    assign cpu_vec  = cpu_res.vec;
    assign cpu_lvl  = cpu_res.lvl;
    assign xfer_req = xfer_res.valid;
    assign xfer_vec = xfer_res.vec;
    assign xfer_lvl = xfer_res.lvl;
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk
    import irq_vec_pkg::*;
#(
    parameter int NUM_SRC = 51,
    parameter int IDX_W   = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] flags,
    input logic [NUM_SRC-1:0] src_en,
    input logic [NUM_SRC-1:0] src_to_xfer,
    input logic [LVL_W-1:0]   cpu_mask,
    input logic               wr_en,
    input logic [IDX_W-1:0]   wr_idx,
    input logic               wr_data,
    input logic               cpu_req,
    input logic [VEC_W-1:0]   cpu_vec,
    input logic [LVL_W-1:0]   cpu_lvl,
    input logic               xfer_req,
    input logic [VEC_W-1:0]   xfer_vec
);
    logic [NUM_SRC-1:0] flags_p, en_p, route_p;
    logic [LVL_W-1:0]   mask_p;
    logic [IDX_W-1:0]   cpu_idx, xfer_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_p <= '0;
            en_p    <= '0;
            route_p <= '0;
            mask_p  <= '0;
        end else begin
            flags_p <= flags;
            en_p    <= src_en;
            route_p <= src_to_xfer;
            mask_p  <= cpu_mask;
        end
    end

    assign cpu_idx  = IDX_W'(cpu_vec - VEC_W'(VEC_BASE));
    assign xfer_idx = IDX_W'(xfer_vec - VEC_W'(VEC_BASE));

    a_r1_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req |-> (cpu_vec >= VEC_W'(VEC_BASE)) && (cpu_vec < VEC_W'(VEC_BASE + NUM_SRC)));

    a_r2_req_from_enabled_flag: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req |-> (flags_p[cpu_idx] && en_p[cpu_idx]));

    a_r4_mask_respected: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req |-> ((cpu_lvl > mask_p) || (cpu_lvl == '1)));

    a_r5_xfer_only_routed: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> (route_p[xfer_idx] && flags_p[xfer_idx] && en_p[xfer_idx]));

    a_r5_cpu_not_routed: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req |-> !route_p[cpu_idx]);

    a_r10_drop_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_p & en_p) == '0) |-> (!cpu_req && !xfer_req));

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_clr
        a_r8_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flags[g]) |-> $past(wr_en && !wr_data && (wr_idx == IDX_W'(g))));
    end
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flags       (flag_vec),
    .src_en      (src_en),
    .src_to_xfer (src_to_xfer),
    .cpu_mask    (cpu_mask),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_data     (wr_data),
    .cpu_req     (cpu_req),
    .cpu_vec     (cpu_vec),
    .cpu_lvl     (cpu_lvl),
    .xfer_req    (xfer_req),
    .xfer_vec    (xfer_vec)
);

// File: tb/irq_vec_ctrl_test.sv
module irq_vec_ctrl_test;
    localparam int NE = 8;
    localparam int NI = 43;
    localparam int NS = NE + NI;
    localparam int NG = (NS + 3) / 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NE-1:0] irq_n = '1;
    logic [NE-1:0] irq_edge = '1;
    logic [NI-1:0] int_req = '0;
    logic [NS-1:0] src_en = '1;
    logic [NS-1:0] src_to_xfer = '0;
    logic [NG*3-1:0] grp_lvl = {NG{3'd1}};
    logic [2:0]    cpu_mask = '0;
    logic          rd_en = 1'b0;
    logic [5:0]    rd_idx = '0;
    logic          wr_en = 1'b0;
    logic [5:0]    wr_idx = '0;
    logic          wr_data = 1'b0;
    logic          rd_flag, cpu_req, xfer_req;
    logic [7:0]    cpu_vec, xfer_vec;
    logic [2:0]    cpu_lvl, xfer_lvl;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    irq_vec_ctrl uut (
        .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .irq_edge(irq_edge),
        .int_req(int_req), .src_en(src_en), .src_to_xfer(src_to_xfer),
        .grp_lvl(grp_lvl), .cpu_mask(cpu_mask), .rd_en(rd_en), .rd_idx(rd_idx),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .rd_flag(rd_flag),
        .cpu_req(cpu_req), .cpu_vec(cpu_vec), .cpu_lvl(cpu_lvl),
        .xfer_req(xfer_req), .xfer_vec(xfer_vec), .xfer_lvl(xfer_lvl)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_int(int k);
        int_req[k] = 1'b1;
        tick(1);
        int_req[k] = 1'b0;
    endtask

    task automatic clear_src(int idx);
        rd_en = 1'b1; rd_idx = 6'(idx);
        tick(1);
        rd_en = 1'b0;
        wr_en = 1'b1; wr_idx = 6'(idx); wr_data = 1'b0;
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic set_grp(int g, int lv);
        grp_lvl[g*3 +: 3] = 3'(lv);
    endtask

    task automatic t_reset();
        chk("R11 cpu_req", int'(cpu_req), 0);
        chk("R11 xfer_req", int'(xfer_req), 0);
        chk("R11 rd_flag", int'(rd_flag), 0);
    endtask

    task automatic t_basic();
        pulse_int(5);
        chk("R10 not yet registered", int'(cpu_req), 0);
        tick(1);
        chk("R10 req", int'(cpu_req), 1);
        chk("R1 vec int5", int'(cpu_vec), 29);
        chk("R1 lvl", int'(cpu_lvl), 1);
        clear_src(13);
        tick(1);
        chk("R10 drop", int'(cpu_req), 0);
    endtask

    task automatic t_clear_rule();
        pulse_int(6);
        tick(1);
        wr_en = 1'b1; wr_idx = 6'd14; wr_data = 1'b0;
        tick(1);
        wr_en = 1'b0;
        tick(1);
        chk("R8 unread write0 ignored", int'(cpu_req), 1);
        chk("R8 vec", int'(cpu_vec), 30);
        rd_en = 1'b1; rd_idx = 6'd14;
        tick(1);
        rd_en = 1'b0;
        chk("R8 read flag", int'(rd_flag), 1);
        wr_en = 1'b1; wr_idx = 6'd14; wr_data = 1'b1;
        tick(1);
        wr_en = 1'b0;
        tick(1);
        chk("R8 write1 ignored", int'(cpu_req), 1);
        clear_src(14);
        tick(1);
        chk("R8 cleared", int'(cpu_req), 0);
    endtask

    task automatic t_enable();
        src_en[15] = 1'b0;
        pulse_int(7);
        tick(2);
        chk("R2 disabled no req", int'(cpu_req), 0);
        rd_en = 1'b1; rd_idx = 6'd15;
        tick(1);
        rd_en = 1'b0;
        chk("R2 flag latched", int'(rd_flag), 1);
        src_en[15] = 1'b1;
        tick(1);
        chk("R2 enabled req", int'(cpu_req), 1);
        chk("R2 vec", int'(cpu_vec), 31);
        clear_src(15);
        tick(1);
        chk("R2 cleared", int'(cpu_req), 0);
    endtask

    task automatic t_priority();
        int_req[10] = 1'b1; int_req[2] = 1'b1;
        tick(1);
        int_req[10] = 1'b0; int_req[2] = 1'b0;
        tick(1);
        chk("R3 tie lower vec", int'(cpu_vec), 26);
        set_grp(4, 5);
        tick(1);
        chk("R3 higher level wins", int'(cpu_vec), 34);
        chk("R3 level", int'(cpu_lvl), 5);
        pulse_int(8);
        tick(1);
        chk("R3 within group", int'(cpu_vec), 32);
        set_grp(2, 5);
        tick(1);
        chk("R3 groups equal", int'(cpu_vec), 26);
        set_grp(2, 1); set_grp(4, 1);
        clear_src(10); clear_src(16); clear_src(18);
        tick(1);
        chk("R3 cleared", int'(cpu_req), 0);
    endtask

    task automatic t_mask();
        cpu_mask = 3'd1;
        pulse_int(3);
        tick(1);
        chk("R4 equal level masked", int'(cpu_req), 0);
        cpu_mask = 3'd0;
        tick(1);
        chk("R4 unmasked", int'(cpu_vec), 27);
        set_grp(2, 7); cpu_mask = 3'd7;
        tick(1);
        chk("R4 level7 forwarded", int'(cpu_req), 1);
        chk("R4 level7 value", int'(cpu_lvl), 7);
        set_grp(2, 6);
        tick(1);
        chk("R4 level6 under mask7", int'(cpu_req), 0);
        set_grp(2, 1); cpu_mask = 3'd0;
        clear_src(11);
        tick(1);
        chk("R4 cleared", int'(cpu_req), 0);
    endtask

    task automatic t_route();
        src_to_xfer[20] = 1'b1; cpu_mask = 3'd7;
        pulse_int(12);
        tick(1);
        chk("R5 xfer req", int'(xfer_req), 1);
        chk("R5 xfer vec", int'(xfer_vec), 36);
        chk("R5 cpu excluded", int'(cpu_req), 0);
        src_to_xfer[20] = 1'b0; cpu_mask = 3'd0;
        tick(1);
        chk("R5 back to cpu", int'(cpu_vec), 36);
        chk("R5 xfer idle", int'(xfer_req), 0);
        clear_src(20);
        tick(1);
        chk("R5 cleared", int'(cpu_req), 0);
    endtask

    task automatic t_edge();
        irq_n[3] = 1'b0;
        tick(3);
        chk("R6 not before 4th edge", int'(cpu_req), 0);
        tick(1);
        chk("R6 edge vec", int'(cpu_vec), 19);
        clear_src(3);
        tick(1);
        chk("R6 no reset while low", int'(cpu_req), 0);
        irq_n[3] = 1'b1;
        tick(4);
        chk("R6 rising no set", int'(cpu_req), 0);
        irq_n[0] = 1'b0; irq_n[7] = 1'b0;
        tick(4);
        chk("R1 irq0 vec", int'(cpu_vec), 16);
        clear_src(0);
        tick(1);
        chk("R1 irq7 vec", int'(cpu_vec), 23);
        clear_src(7);
        irq_n[0] = 1'b1; irq_n[7] = 1'b1;
        tick(4);
        chk("R6 idle", int'(cpu_req), 0);
    endtask

    task automatic t_level();
        irq_edge[5] = 1'b0;
        irq_n[5] = 1'b0;
        tick(4);
        chk("R7 level vec", int'(cpu_vec), 21);
        clear_src(5);
        tick(1);
        chk("R9 R7 set wins while low", int'(cpu_req), 1);
        irq_n[5] = 1'b1;
        tick(3);
        clear_src(5);
        tick(1);
        chk("R7 cleared after release", int'(cpu_req), 0);
        irq_edge[5] = 1'b1;
    endtask

    task automatic t_set_clear();
        pulse_int(1);
        rd_en = 1'b1; rd_idx = 6'd9;
        tick(1);
        rd_en = 1'b0;
        wr_en = 1'b1; wr_idx = 6'd9; wr_data = 1'b0; int_req[1] = 1'b1;
        tick(1);
        wr_en = 1'b0; int_req[1] = 1'b0;
        tick(1);
        chk("R9 set beats clear", int'(cpu_req), 1);
        chk("R9 vec", int'(cpu_vec), 25);
        clear_src(9);
        tick(1);
        chk("R9 cleared", int'(cpu_req), 0);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_basic();
        t_clear_rule();
        t_enable();
        t_priority();
        t_mask();
        t_route();
        t_edge();
        t_level();
        t_set_clear();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule